// File: doc/BRIEF.md
# Programmable Priority Interrupt Resolver

This block picks, once per clock, the most urgent active interrupt for each of two interrupt classes: a fast class and a normal class. Urgency does not follow the source numbering. Software sets it instead through a table of 40 priority slots. Each slot holds a source number and a flag that marks the slot as in use. Slot 0 is the most urgent. For each class, the first slot in use whose source is pending, enabled and routed to that class sets the answer.

The block receives three 40-bit vectors from elsewhere in the chip: pending sources, enabled sources and class routing. It also has a simple register port through which software writes and reads the slots. The fast-class answer and the normal-class answer are packed into one 32-bit result word and registered. Each answer carries its own valid flag and source number. Interrupt entry code reads this word to find, in a single access, which handler to run for each class.

The block has no sequencing state. It has a single operating state, RUN, that it enters when reset is released. In RUN, the result register reloads on every clock edge, and a slot write takes effect on the edge at which it is presented. The only transition is reset, which returns the block to RUN with every slot cleared and the idle result word.

Top module: `irqp_arbiter`

## Requirements
- R1: After reset, the result word reads 0x003F003F and every slot reads 0.
- R2: A slot write keeps only bit 31 (in-use flag) and bits 5:0 (source number) of the written data. Every other bit reads back as 0.
- R3: Slot k is reached at byte address 0x1C+4k for k = 0 to 31, and at 0xB0+4(k-32) for k = 32 to 39. A read from any other address, including a misaligned one, returns 0. A write to any other address changes no slot.
- R4: A slot takes part in selection only when its in-use flag is 1 and its source number is below 40.
- R5: For each class, the reported source comes from the lowest-numbered slot that takes part and whose source is active in that class.
- R6: Result bit 15 is the fast-class valid flag, and bits 5:0 hold the fast-class source. Bit 31 is the normal-class valid flag, and bits 21:16 hold the normal-class source. All other bits are 0.
- R7: A class with no qualifying source reports valid 0 and source field 0x3F.
- R8: A source is active in the fast class when it is pending, enabled and its routing bit is 1. It is active in the normal class when it is pending, enabled and its routing bit is 0. The two classes are resolved independently.
- R9: Several slots may name the same source. The lowest-numbered of them decides, and the repeat causes no other effect.
- R10: The result word reflects the inputs and slot contents present at the previous rising clock edge, not those of the current cycle.
- R11: A source that is pending but not enabled is never reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pend_i | input | 40 | Pending sources, one bit per source |
| en_i | input | 40 | Enabled sources |
| route_i | input | 40 | Class routing: 1 = fast, 0 = normal |
| cfg_we | input | 1 | Slot write strobe |
| cfg_addr | input | 8 | Byte address for slot read and write |
| cfg_wdata | input | 32 | Slot write data |
| cfg_rdata | output | 32 | Slot read data for cfg_addr (combinational) |
| res_o | output | 32 | Registered result word, both classes |

## Verification
The only internal state is the slot table and the result register. A wrong slot shows up in two places. It shows in the readback of that slot in the same cycle. It also shows in the result word one edge after the first input pattern that makes that slot the winner. Because of that, the result is compared against a behavioural model on every clock, under pattern sequences that move the winner between slots, between classes and onto duplicate or unqualified slots. A decode error in the address map shows up as a changed neighbour slot on a full-table readback that runs right after writes to gap and misaligned addresses.

// File: rtl/irqp_pkg.sv
package irqp_pkg;
    localparam int NUM_SRC   = 40;
    localparam int SRC_W     = 6;
    localparam int WORD_W    = 32;
    localparam int LOW_CNT   = 32;
    localparam int LOW_BASE  = 'h1C;
    localparam int HIGH_BASE = 'hB0;

    localparam int FAST_VLD_BIT = 15;
    localparam int FAST_ID_LSB  = 0;
    localparam int NORM_VLD_BIT = 31;
    localparam int NORM_ID_LSB  = 16;

    localparam logic [SRC_W-1:0]  NO_SRC    = '1;
    localparam logic [WORD_W-1:0] SLOT_KEEP = 32'h8000_003F;

    typedef struct packed {
        logic             used;
        logic [SRC_W-1:0] src;
    } slot_t;

    typedef struct packed {
        logic             hit;
        logic [SRC_W-1:0] src;
    } pick_t;

    typedef enum logic [0:0] {
        CLS_FAST = 1'b0,
        CLS_NORM = 1'b1
    } cls_e;

    function automatic logic [WORD_W-1:0] pack_result(pick_t fast, pick_t norm);
        logic [WORD_W-1:0] w;
        w = '0;
        w[FAST_VLD_BIT]                 = fast.hit;
        w[FAST_ID_LSB +: SRC_W]         = fast.src;
        w[NORM_VLD_BIT]                 = norm.hit;
        w[NORM_ID_LSB +: SRC_W]         = norm.src;
        return w;
    endfunction
endpackage

// File: rtl/irqp_slot_table.sv
module irqp_slot_table
    import irqp_pkg::*;
#(
    parameter int N_SLOTS = NUM_SRC,
    parameter int N_LOW   = LOW_CNT,
    parameter int A_LOW   = LOW_BASE,
    parameter int A_HIGH  = HIGH_BASE,
    parameter int ADDR_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we_i,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [WORD_W-1:0]         wdata_i,
    output logic [WORD_W-1:0]         rdata_o,
    output slot_t [N_SLOTS-1:0]       slots_o
);
    localparam int IDX_W  = $clog2(N_SLOTS);
    localparam int LOW_END  = A_LOW + 4 * N_LOW;
    localparam int HIGH_END = A_HIGH + 4 * (N_SLOTS - N_LOW);

    logic             sel_hit;
    logic [IDX_W-1:0] sel_idx;
    slot_t [N_SLOTS-1:0] tbl_q;

    // Address decode: two aligned windows, stride 4.
    always_comb begin
        int a;
        a       = int'(addr_i);
        sel_hit = 1'b0;
        sel_idx = '0;
        if (addr_i[1:0] == 2'b00) begin
            if (a >= A_LOW && a < LOW_END) begin
                sel_hit = 1'b1;
                sel_idx = IDX_W'((a - A_LOW) / 4);
            end else if (a >= A_HIGH && a < HIGH_END) begin
                sel_hit = 1'b1;
                sel_idx = IDX_W'(N_LOW + (a - A_HIGH) / 4);
            end
        end
    end

    // One storage cell per slot.
    for (genvar k = 0; k < N_SLOTS; k++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tbl_q[k] <= '0;
            end else if (we_i && sel_hit && sel_idx == IDX_W'(k)) begin
                tbl_q[k].used <= wdata_i[WORD_W-1];
                tbl_q[k].src  <= wdata_i[SRC_W-1:0];
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        if (sel_hit) begin
            rdata_o[WORD_W-1]  = tbl_q[sel_idx].used;
            rdata_o[SRC_W-1:0] = tbl_q[sel_idx].src;
        end
    end

    assign slots_o = tbl_q;

    // R2
    write_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(we_i && sel_hit) && addr_i == $past(addr_i))
            |-> rdata_o == ($past(wdata_i) & SLOT_KEEP));

    // R3
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i[1:0] != 2'b00) |-> rdata_o == '0);
endmodule

// File: rtl/irqp_class_pick.sv
module irqp_class_pick
    import irqp_pkg::*;
#(
    parameter int N_SLOTS = NUM_SRC
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  slot_t [N_SLOTS-1:0]  slots_i,
    input  logic  [N_SLOTS-1:0]  cand_i,
    output pick_t                pick_o
);
    localparam int SPAN = 2 ** SRC_W;

    logic [SPAN-1:0] cand_ext;
    assign cand_ext = SPAN'(cand_i);

    // Scan from the least urgent slot so the most urgent one is applied last.
    always_comb begin
        pick_o.hit = 1'b0;
        pick_o.src = NO_SRC;
        for (int s = N_SLOTS - 1; s >= 0; s--) begin
            if (slots_i[s].used && int'(slots_i[s].src) < N_SLOTS
                && cand_ext[slots_i[s].src]) begin
                pick_o.hit = 1'b1;
                pick_o.src = slots_i[s].src;
            end
        end
    end

    // R8 R11
    pick_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pick_o.hit |-> (int'(pick_o.src) < N_SLOTS) && cand_ext[pick_o.src]);

    // R7
    idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pick_o.hit |-> pick_o.src == NO_SRC);

    // R5
    slot0_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slots_i[0].used && int'(slots_i[0].src) < N_SLOTS && cand_ext[slots_i[0].src])
            |-> pick_o.hit && pick_o.src == slots_i[0].src);
endmodule

// File: rtl/irqp_arbiter.sv
module irqp_arbiter
    import irqp_pkg::*;
#(
    parameter int N_SLOTS = NUM_SRC,
    parameter int ADDR_W  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_SLOTS-1:0]   pend_i,
    input  logic [N_SLOTS-1:0]   en_i,
    input  logic [N_SLOTS-1:0]   route_i,
    input  logic                 cfg_we,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [WORD_W-1:0]    cfg_wdata,
    output logic [WORD_W-1:0]    cfg_rdata,
    output logic [WORD_W-1:0]    res_o
);
    localparam pick_t IDLE_PICK = '{hit: 1'b0, src: NO_SRC};
    localparam logic [WORD_W-1:0] IDLE_WORD = pack_result(IDLE_PICK, IDLE_PICK);

    slot_t [N_SLOTS-1:0] slots;
    logic  [N_SLOTS-1:0] active;
    pick_t               picks [2];
    logic  [WORD_W-1:0]  res_q;

    irqp_slot_table #(
        .N_SLOTS (N_SLOTS),
        .ADDR_W  (ADDR_W)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we),
        .addr_i  (cfg_addr),
        .wdata_i (cfg_wdata),
        .rdata_o (cfg_rdata),
        .slots_o (slots)
    );

    assign active = pend_i & en_i;

    for (genvar c = 0; c < 2; c++) begin : g_cls
        logic [N_SLOTS-1:0] cand;
        if (c == int'(CLS_FAST)) begin : g_fast
            assign cand = active & route_i;
        end else begin : g_norm
            assign cand = active & ~route_i;
        end
        irqp_class_pick #(.N_SLOTS(N_SLOTS)) u_pick (
            .clk     (clk),
            .rst_n   (rst_n),
            .slots_i (slots),
            .cand_i  (cand),
            .pick_o  (picks[c])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= IDLE_WORD;
        else        res_q <= pack_result(picks[CLS_FAST], picks[CLS_NORM]);
    end

    assign res_o = res_q;

    // R7
    all_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active == '0) |=> res_o == IDLE_WORD);

    // R6
    spare_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_o[14:6] == '0 && res_o[30:22] == '0);

    // R8
    fast_routed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active & route_i) == '0 |=> !res_o[FAST_VLD_BIT]);
endmodule

// File: tb/irqp_arbiter_tb.sv
module irqp_arbiter_tb;
    localparam int NS = 40;
    localparam logic [31:0] IDLE = 32'h003F_003F;
    localparam logic [31:0] KEEP = 32'h8000_003F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [NS-1:0] pend_i = '0, en_i = '0, route_i = '0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata, res_o;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;
    bit cmp_on = 1'b0;
    logic [31:0] tbl_m [NS];
    logic [31:0] exp_res = IDLE;

    always #4 clk = ~clk;

    irqp_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .en_i(en_i), .route_i(route_i),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .res_o(res_o)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    function automatic int slot_of(logic [7:0] a);
        int v = int'(a);
        if (v % 4 != 0) return -1;
        if (v >= 'h1C && v <= 'h98) return (v - 'h1C) / 4;
        if (v >= 'hB0 && v <= 'hCC) return 32 + (v - 'hB0) / 4;
        return -1;
    endfunction

    function automatic logic [7:0] addr_of(int k);
        return (k < 32) ? 8'(8'h1C + 4 * k) : 8'(8'hB0 + 4 * (k - 32));
    endfunction

    function automatic logic [31:0] model_word();
        int fsrc = 63, nsrc = 63;
        bit fv = 0, nv = 0;
        for (int s = 0; s < NS; s++) begin
            int id = int'(tbl_m[s][5:0]);
            if (tbl_m[s][31] && id < NS && pend_i[id] && en_i[id]) begin
                if (route_i[id] && !fv) begin fv = 1; fsrc = id; end
                if (!route_i[id] && !nv) begin nv = 1; nsrc = id; end
            end
        end
        return {nv, 9'd0, 6'(nsrc), fv, 9'd0, 6'(fsrc)};
    endfunction

    // Reference model: evaluated with the state seen at each rising edge.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_res = IDLE;
            for (int s = 0; s < NS; s++) tbl_m[s] = '0;
        end else begin
            exp_res = model_word();
            if (cfg_we && slot_of(cfg_addr) >= 0)
                tbl_m[slot_of(cfg_addr)] = cfg_wdata & KEEP;
        end
    end

    always @(negedge clk) if (cmp_on && !done) check("R10 per-cycle model", res_o, exp_res);

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(string tag, logic [7:0] a, logic [31:0] exp);
        cfg_addr = a; #1;
        check(tag, cfg_rdata, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_on = 1'b1;
        // R1 reset state
        check("R1 reset result", res_o, IDLE);
        rd_chk("R1 slot0 reset", addr_of(0), 32'h0);
        rd_chk("R1 slot39 reset", addr_of(39), 32'h0);

        // R2 masking
        wr(addr_of(0), 32'hFFFF_FFFF);
        rd_chk("R2 write keep", addr_of(0), 32'h8000_003F);

        // R4 source 63 and source 40 are out of range
        pend_i = '1; en_i = '1; route_i = '1;
        step(); step();
        check("R4 src 63 ignored", res_o, IDLE);
        wr(addr_of(0), 32'h8000_0028);
        step();
        check("R4 src 40 ignored", res_o, IDLE);

        wr(addr_of(0), 32'h8000_0005);
        wr(addr_of(1), 32'h8000_000C);
        wr(addr_of(2), 32'h0000_0007);
        wr(addr_of(35), 32'h8000_0027);

        // R8 R6 R4: slot2 not in use so source 7 stays unreported
        pend_i = '0; pend_i[7] = 1; pend_i[12] = 1; pend_i[39] = 1;
        route_i = '0; route_i[12] = 1;
        step();
        check("R6 R8 both classes", res_o, 32'h8027_800C);

        // R5 slot0 outranks slot1
        pend_i[5] = 1; route_i[5] = 1;
        step();
        check("R5 slot0 wins fast", res_o, 32'h8027_8005);

        // R11 disabled source
        en_i[5] = 0;
        step();
        check("R11 disabled ignored", res_o, 32'h8027_800C);

        // R7 R5: all normal, slot1 outranks slot35
        route_i = '0;
        step();
        check("R7 R5 fast idle", res_o, 32'h800C_003F);

        pend_i = '0;
        step();
        check("R7 both idle", res_o, IDLE);

        // R9 duplicates
        wr(addr_of(4), 32'h8000_0003);
        wr(addr_of(36), 32'h8000_0003);
        pend_i[3] = 1; pend_i[39] = 1; route_i[3] = 1;
        step();
        check("R9 duplicate source", res_o, 32'h8027_8003);
        wr(addr_of(4), 32'h0);
        step();
        check("R9 lower copy removed", res_o, 32'h8027_8003);

        // R3 map edges and gaps
        wr(8'h9C, 32'h8000_0011);
        wr(8'h1D, 32'h8000_0011);
        wr(8'hD0, 32'h8000_0011);
        wr(8'h18, 32'h8000_0011);
        for (int k = 0; k < NS; k++) rd_chk("R3 slot unchanged", addr_of(k), tbl_m[k]);
        rd_chk("R3 gap reads 0", 8'h9C, 32'h0);
        rd_chk("R3 misaligned reads 0", 8'h1D, 32'h0);
        wr(8'hB0, 32'h8000_0013);
        rd_chk("R3 slot32 address", addr_of(32), 32'h8000_0013);
        wr(8'hCC, 32'h8000_0021);
        rd_chk("R3 slot39 address", 8'hCC, 32'h8000_0021);
        pend_i = '0; pend_i[19] = 1; route_i = '0; route_i[19] = 1;
        step();
        check("R3 slot32 selects", res_o, 32'h003F_8013);

        // R10 one-edge latency
        pend_i = '0;
        step();
        pend_i[12] = 1;
        #1;
        check("R10 before edge", res_o, IDLE);
        step();
        check("R10 after edge", res_o, 32'h800C_003F);

        step();
        finish_run();
    end
endmodule